// File: doc/BRIEF.md
# Reset Cause Recorder and Memory-Controller Reset Splitter

This block tracks which reset source was responsible for the most recent reset. It keeps one sticky flag per source and drives two active-low resets toward an external memory controller. Five level inputs feed it: power-on reset, the external reset pin, the watchdog timeout, the watchdog reset enable and brown-out detect. All of them are already synchronized to the block clock. Each flag follows its own set and clear rules. Software can read the flags and clear them by writing ones through a small register port.

A second register holds two configuration bits. The first selects the fast GPIO access mode. The second tells the block to spare the memory controller's cold reset during warm resets (external pin or watchdog), so that refresh state survives them. This register is cleared only by power-on or brown-out, so its settings persist across warm resets. Both memory-controller resets assert asynchronously as soon as their event is seen. They release synchronously, a fixed number of rising edges after the event ends.

Top module: `rst_cause_unit`

## Requirements
- R1: After the block reset `rst_n` releases with no source asserted, address 0 reads 0x01, address 1 reads 0x00, and both memory-controller resets stay low for one rising edge and are high after the second.
- R2: While power-on reset is asserted, address 0 reads 0x01 on every cycle after the first, and software writes to it have no effect.
- R3: If the external reset is still asserted in the cycle power-on reset deasserts, address 0 reads 0x03 in the following cycle (bit 0 power-on, bit 1 external).
- R4: On the cycle the external reset deasserts, status bit 1 is set and bit 2 (watchdog) is cleared. Bits 0 and 3 are unchanged.
- R5: When the watchdog timeout deasserts while it had been asserted together with the enable, status bit 2 is set. A timeout with the enable at 0 changes neither the status nor the resets.
- R6: On the cycle brown-out deasserts, status bit 3 is set and bit 2 is cleared. Bit 1 is unchanged.
- R7: Writing to address 0 clears each status bit whose written data bit is 1. Data bits written as 0 have no effect. Bits 7:4 always read 0.
- R8: A hardware set and a software clear of the same status bit in the same cycle leave the bit set.
- R9: Address 1 holds bit 0 (fast GPIO mode, driven on `gpio_fast_mode_o`) and bit 1 (memory-controller cold-reset disable). Bits 7:2 read 0.
- R10: The control register keeps its value through external and watchdog resets, and is cleared to 0 by power-on reset or brown-out.
- R11: With the disable bit at 0, both memory-controller resets are low while any reset source is asserted.
- R12: With the disable bit at 1, the cold reset is low only for power-on or brown-out. The warm reset is low for every source. The cold reset is never low while the warm reset is high.
- R13: A memory-controller reset goes low in the same cycle its event appears, without waiting for a clock edge. It returns high on the second rising edge after the event ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block itself |
| por_i | input | 1 | Power-on reset level, synchronized |
| ext_rst_i | input | 1 | External reset pin level, synchronized |
| wdt_timeout_i | input | 1 | Watchdog timeout level |
| wdt_rst_en_i | input | 1 | Watchdog timeout is allowed to cause a reset |
| bod_i | input | 1 | Brown-out detect level, synchronized |
| reg_addr_i | input | 1 | Register select: 0 status, 1 control |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register, combinational |
| gpio_fast_mode_o | output | 1 | Control bit 0 |
| mc_warm_rst_n_o | output | 1 | Memory-controller warm reset, active low |
| mc_cold_rst_n_o | output | 1 | Memory-controller cold reset, active low |

## Verification
The bench holds the external reset across the end of a power-on reset. A design that samples only edges would then lose the external flag. It places a software clear on the same cycle as a hardware set, where the wrong priority drops the flag. It runs watchdog timeouts with the enable off and then on, and checks that the watchdog flag is cleared by external and brown-out resets. A design that let every source clear every other flag would lose bit 1 or bit 3 in these runs. With the cold-reset disable set, it checks that the cold reset stays high through external and watchdog resets but still falls for brown-out. It also checks that the control register survives warm resets and is cleared by power-on, and it counts the release edges of both memory-controller resets.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 1;
  localparam int unsigned NSRC    = 4;
  localparam int unsigned CTRL_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_CAUSE = 1'b0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 1'b1;

  // cause bit positions (software decodes these)
  localparam int unsigned B_POR = 0;
  localparam int unsigned B_EXT = 1;
  localparam int unsigned B_WDT = 2;
  localparam int unsigned B_BOD = 3;

  // control bit positions
  localparam int unsigned C_GPIO = 0;
  localparam int unsigned C_DIS  = 1;

  localparam logic [NSRC-1:0] CAUSE_PWRUP = 4'b0001;
endpackage

// File: rtl/rcc_cause_reg.sv
module rcc_cause_reg
  import rcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl_i,
  input  logic            sw_clr_en_i,
  input  logic [NSRC-1:0] sw_clr_mask_i,
  output logic [NSRC-1:0] cause_o
);
  logic [NSRC-1:0] prev_q, cause_q, cause_d, fall, hw_set, hw_clr, sw_clr;
  logic            cause_en;

  always_comb begin
    fall   = prev_q & ~lvl_i;
    hw_set = '0;
    hw_clr = '0;
    hw_set[B_EXT] = fall[B_EXT];
    hw_set[B_WDT] = fall[B_WDT];
    hw_set[B_BOD] = fall[B_BOD];
    if (fall[B_POR]) hw_set = hw_set | lvl_i | CAUSE_PWRUP;
    hw_clr[B_WDT] = fall[B_EXT] | fall[B_BOD];
    sw_clr   = sw_clr_en_i ? sw_clr_mask_i : '0;
    cause_en = lvl_i[B_POR] | (|fall) | sw_clr_en_i;
    if (lvl_i[B_POR]) cause_d = CAUSE_PWRUP;
    else              cause_d = (cause_q & ~hw_clr & ~sw_clr) | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= CAUSE_PWRUP;
      cause_q <= CAUSE_PWRUP;
    end else begin
      prev_q <= lvl_i;
      if (cause_en) cause_q <= cause_d;
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/rcc_ctrl_reg.sv
module rcc_ctrl_reg
  import rcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cold_clr_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;

  always_comb begin
    ctrl_en = cold_clr_i | wr_en_i;
    ctrl_d  = cold_clr_i ? '0 : wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/rcc_rel_sync.sv
module rcc_rel_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  output logic rst_out_n
);
  logic              clr_n;
  logic [STAGES-1:0] chain_q, chain_d;

  assign clr_n   = rst_n & ~event_i;
  assign chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_out_n = chain_q[STAGES-1];
endmodule

// File: rtl/rst_cause_unit.sv
module rst_cause_unit
  import rcc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_i,
  input  logic              ext_rst_i,
  input  logic              wdt_timeout_i,
  input  logic              wdt_rst_en_i,
  input  logic              bod_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              gpio_fast_mode_o,
  output logic              mc_warm_rst_n_o,
  output logic              mc_cold_rst_n_o
);
  localparam int unsigned NOUT = 2;

  logic [NSRC-1:0]   lvl, cause_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              cold_src, warm_src, sel_cause, sel_ctrl;
  logic [NOUT-1:0]   evt, rst_n_vec;

  always_comb begin
    lvl        = '0;
    lvl[B_POR] = por_i;
    lvl[B_EXT] = ext_rst_i;
    lvl[B_WDT] = wdt_timeout_i & wdt_rst_en_i;
    lvl[B_BOD] = bod_i;
    cold_src   = por_i | bod_i;
    warm_src   = |lvl;
    sel_cause  = (reg_addr_i == ADDR_CAUSE);
    sel_ctrl   = (reg_addr_i == ADDR_CTRL);
    evt[0]     = warm_src;
    evt[1]     = cold_src | (~ctrl_q[C_DIS] & warm_src);
  end

  rcc_cause_reg u_cause (
    .clk          (clk),
    .rst_n        (rst_n),
    .lvl_i        (lvl),
    .sw_clr_en_i  (reg_wr_i & sel_cause),
    .sw_clr_mask_i(reg_wdata_i[NSRC-1:0]),
    .cause_o      (cause_q)
  );

  rcc_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cold_clr_i(cold_src),
    .wr_en_i   (reg_wr_i & sel_ctrl),
    .wdata_i   (reg_wdata_i[CTRL_W-1:0]),
    .ctrl_o    (ctrl_q)
  );

  for (genvar g = 0; g < NOUT; g++) begin : g_rel
    rcc_rel_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .event_i  (evt[g]),
      .rst_out_n(rst_n_vec[g])
    );
  end

  assign reg_rdata_o      = sel_cause ? DATA_W'(cause_q) : DATA_W'(ctrl_q);
  assign gpio_fast_mode_o = ctrl_q[C_GPIO];
  assign mc_warm_rst_n_o  = rst_n_vec[0];
  assign mc_cold_rst_n_o  = rst_n_vec[1];
endmodule

// File: rtl/rst_cause_unit_chk.sv
module rst_cause_unit_chk
  import rcc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              por_i,
  input logic              ext_rst_i,
  input logic              wdt_timeout_i,
  input logic              wdt_rst_en_i,
  input logic              bod_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_wr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              mc_warm_rst_n_o,
  input logic              mc_cold_rst_n_o,
  input logic [NSRC-1:0]   cause,
  input logic [CTRL_W-1:0] ctrl
);
  a_r2_por_forces_status: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (cause == CAUSE_PWRUP));

  a_r7_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ADDR_CAUSE) |-> (reg_rdata_o[DATA_W-1:NSRC] == '0));

  a_r10_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_i && !bod_i && !(reg_wr_i && reg_addr_i == ADDR_CTRL)) |=> $stable(ctrl));

  a_r11_warm_on_any: assert property (@(posedge clk) disable iff (!rst_n)
    (por_i || ext_rst_i || (wdt_timeout_i && wdt_rst_en_i) || bod_i) |-> !mc_warm_rst_n_o);

  a_r12_cold_spared: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[C_DIS] && !por_i && !bod_i && $past(mc_cold_rst_n_o)) |-> mc_cold_rst_n_o);

  a_r12_cold_within_warm: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_cold_rst_n_o |-> !mc_warm_rst_n_o);
endmodule

bind rst_cause_unit rst_cause_unit_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .por_i          (por_i),
  .ext_rst_i      (ext_rst_i),
  .wdt_timeout_i  (wdt_timeout_i),
  .wdt_rst_en_i   (wdt_rst_en_i),
  .bod_i          (bod_i),
  .reg_addr_i     (reg_addr_i),
  .reg_wr_i       (reg_wr_i),
  .reg_rdata_o    (reg_rdata_o),
  .mc_warm_rst_n_o(mc_warm_rst_n_o),
  .mc_cold_rst_n_o(mc_cold_rst_n_o),
  .cause          (cause_q),
  .ctrl           (ctrl_q)
);

// File: tb/rst_cause_unit_tb_top.sv
module rst_cause_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, por, ext, wdt_to, wdt_en, bod, addr, wr, gpio, warm_n, cold_n;
  logic [7:0] wdata, rdata;
  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rst_cause_unit dut_i (
    .clk(clk), .rst_n(rst_n), .por_i(por), .ext_rst_i(ext),
    .wdt_timeout_i(wdt_to), .wdt_rst_en_i(wdt_en), .bod_i(bod),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .gpio_fast_mode_o(gpio),
    .mc_warm_rst_n_o(warm_n), .mc_cold_rst_n_o(cold_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  // src: 0 ext, 1 watchdog timeout, 2 bod, 3 por
  task automatic drive(input int src, input logic v);
    case (src)
      0: ext = v;
      1: wdt_to = v;
      2: bod = v;
      default: por = v;
    endcase
  endtask

  // asserted for 2 cycles; reports reset levels seen mid-event; waits out the release
  task automatic pulse(input int src, output logic w_mid, output logic c_mid);
    drive(src, 1'b1); #1;
    w_mid = warm_n; c_mid = cold_n;
    @(negedge clk); @(negedge clk);
    drive(src, 1'b0);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rst_n = 1'b1; #1;
    chk("R1 warm held after rst_n", {7'd0, warm_n}, 8'h00);
    @(negedge clk);
    chk("R1 warm after 1 edge", {7'd0, warm_n}, 8'h00);
    chk("R1 cold after 1 edge", {7'd0, cold_n}, 8'h00);
    @(negedge clk);
    chk("R1 warm after 2 edges", {7'd0, warm_n}, 8'h01);
    chk("R1 cold after 2 edges", {7'd0, cold_n}, 8'h01);
    rd(1'b0, d); chk("R1 status", d, 8'h01);
    rd(1'b1, d); chk("R1 control", d, 8'h00);
  endtask

  task automatic t_ext();
    logic [7:0] d;
    ext = 1'b1; #1;
    chk("R11 warm low on ext", {7'd0, warm_n}, 8'h00);
    chk("R11 cold low on ext", {7'd0, cold_n}, 8'h00);
    @(negedge clk); @(negedge clk);
    ext = 1'b0; #1;
    chk("R13 warm still low at release", {7'd0, warm_n}, 8'h00);
    @(negedge clk);
    chk("R13 warm low after 1 edge", {7'd0, warm_n}, 8'h00);
    @(negedge clk);
    chk("R13 warm high after 2 edges", {7'd0, warm_n}, 8'h01);
    chk("R13 cold high after 2 edges", {7'd0, cold_n}, 8'h01);
    rd(1'b0, d); chk("R4 ext sets bit1", d, 8'h03);
  endtask

  task automatic t_wdt_bod();
    logic [7:0] d;
    logic w, c;
    wdt_en = 1'b0;
    pulse(1, w, c);
    chk("R5 disabled timeout no reset", {7'd0, w}, 8'h01);
    rd(1'b0, d); chk("R5 disabled timeout no flag", d, 8'h03);
    wdt_en = 1'b1;
    pulse(1, w, c);
    chk("R11 warm low on watchdog", {7'd0, w}, 8'h00);
    rd(1'b0, d); chk("R5 enabled timeout sets bit2", d, 8'h07);
    pulse(0, w, c);
    rd(1'b0, d); chk("R4 ext clears bit2", d, 8'h03);
    pulse(1, w, c);
    pulse(2, w, c);
    rd(1'b0, d); chk("R6 bod sets bit3 clears bit2", d, 8'h0B);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    wr_reg(1'b0, 8'h00);
    rd(1'b0, d); chk("R7 write zero no effect", d, 8'h0B);
    wr_reg(1'b0, 8'hF2);
    rd(1'b0, d); chk("R7 clear bit1 upper zero", d, 8'h09);
    wr_reg(1'b0, 8'h09);
    rd(1'b0, d); chk("R7 clear rest", d, 8'h00);
  endtask

  task automatic t_hw_sw();
    logic [7:0] d;
    ext = 1'b1;
    @(negedge clk); @(negedge clk);
    ext = 1'b0; addr = 1'b0; wdata = 8'h02; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    @(negedge clk);
    rd(1'b0, d); chk("R8 hw set beats sw clear", d, 8'h02);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    logic w, c;
    wr_reg(1'b1, 8'hFF);
    rd(1'b1, d); chk("R9 control read", d, 8'h03);
    chk("R9 gpio mode out", {7'd0, gpio}, 8'h01);
    pulse(0, w, c);
    chk("R12 warm low on ext", {7'd0, w}, 8'h00);
    chk("R12 cold spared on ext", {7'd0, c}, 8'h01);
    rd(1'b1, d); chk("R10 control kept over ext", d, 8'h03);
    pulse(1, w, c);
    chk("R12 cold spared on watchdog", {7'd0, c}, 8'h01);
    rd(1'b1, d); chk("R10 control kept over watchdog", d, 8'h03);
    pulse(2, w, c);
    chk("R12 cold low on bod", {7'd0, c}, 8'h00);
    rd(1'b1, d); chk("R10 bod clears control", d, 8'h00);
    wr_reg(1'b1, 8'h02);
    rd(1'b1, d); chk("R9 disable bit alone", d, 8'h02);
    pulse(3, w, c);
    chk("R12 cold low on por", {7'd0, c}, 8'h00);
    rd(1'b1, d); chk("R10 por clears control", d, 8'h00);
  endtask

  task automatic t_por_ext();
    logic [7:0] d;
    por = 1'b1; ext = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(1'b0, d); chk("R2 status during por", d, 8'h01);
    wr_reg(1'b0, 8'hFF);
    rd(1'b0, d); chk("R2 write ignored during por", d, 8'h01);
    @(negedge clk);
    por = 1'b0;
    @(negedge clk);
    rd(1'b0, d); chk("R3 ext held past por", d, 8'h03);
    ext = 1'b0;
    @(negedge clk); @(negedge clk);
    rd(1'b0, d); chk("R3 status after ext ends", d, 8'h03);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; por = 1'b0; ext = 1'b0; wdt_to = 1'b0; wdt_en = 1'b0;
    bod = 1'b0; addr = 1'b0; wr = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    t_ext();
    t_wdt_bod();
    t_w1c();
    t_hw_sw();
    t_ctrl();
    t_por_ext();
    summary();
    $finish;
  end
endmodule